// File: doc/BRIEF.md
# Translation and Per-Die Request Dispatcher

This block sits between the request source of a flash back end and the per-die command engines. Requests arrive with a logical page number and a read/write flag, and they are held in a small master FIFO. The request at the head of that FIFO is sent to an external mapping table through a lookup port. The table answers with a die number and a physical page a fixed number of cycles later. The translated request is then placed into the FIFO that belongs to its die. Each die engine drains its own FIFO with a valid/ready handshake.

Requests leave the master FIFO strictly in the order they arrived. If the die FIFO for the translated head request is full, the head waits there and every request behind it waits too, whatever its own die. Each cycle spent in that state increments a stall counter. The die FIFOs are deeper than the master FIFO, so most of the buffering is at die level. Occupancy and full/empty flags are reported for every queue.

Top module: `ftl_die_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, every queue is empty: `inReady`=1, `mqEmpty`=1, all `dqEmpty` bits are 1, `dieValid`=0, `lookupReq`=0 and `stallCount`=0.
- R2: A request is accepted on a clock edge where `inValid` and `inReady` are both high. `mqCount` gives the number of requests held in the master FIFO. `inReady` and `mqFull` reflect that count: `inReady` is 0 and `mqFull` is 1 exactly when the count equals the master depth. A request offered while the FIFO is full is not stored.
- R3: In the first cycle in which a request is at the master head, `lookupReq` is high for one cycle and `lookupLpa` carries that request's logical page. The dispatcher samples `lookupDie` and `lookupPage` in the cycle exactly `XLAT_LAT` cycles after the `lookupReq` cycle.
- R4: A translated request goes into the die FIFO chosen by `lookupDie`, carrying `lookupPage` and its write flag. With room available, `dieValid` for that die rises `XLAT_LAT`+2 cycles after the edge that accepted the request into an empty dispatcher. The page appears on `diePage[d*PAGE_W +: PAGE_W]` and the flag on `dieWrite[d]`.
- R5: Lookups, and therefore dispatches, happen in the order the requests arrived.
- R6: While the head request's die FIFO is full, no request moves to any die FIFO and `mqCount` does not fall. When the die engine pops that FIFO, the head request enters it in the following cycle.
- R7: `stallCount` increments by exactly one in each cycle in which the head is translated but its die FIFO is full. It holds its value in every other cycle.
- R8: A die FIFO pops on a cycle with `dieValid[d]` and `dieReady[d]` both high, and it delivers entries in the order they were written. `dqCount[d*DQ_CW +: DQ_CW]` gives its occupancy, and `dqFull`/`dqEmpty` reflect that count.
- R9: Each request is looked up once. `lookupReq` stays low while a translated head waits for room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Incoming request valid |
| inReady | output | 1 | Master FIFO can accept |
| inLpa | input | LPA_W | Logical page of incoming request |
| inWrite | input | 1 | Incoming request is a write |
| lookupReq | output | 1 | One-cycle start of a mapping lookup |
| lookupLpa | output | LPA_W | Logical page being translated (master head) |
| lookupDie | input | DIE_W | Die returned by the mapping table |
| lookupPage | input | PAGE_W | Physical page returned by the mapping table |
| dieValid | output | NUM_DIES | Die FIFO has an entry |
| dieReady | input | NUM_DIES | Die engine takes the head entry |
| diePage | output | NUM_DIES*PAGE_W | Head physical page per die |
| dieWrite | output | NUM_DIES | Head write flag per die |
| mqCount | output | MQ_CW | Master FIFO occupancy |
| mqFull | output | 1 | Master FIFO full |
| mqEmpty | output | 1 | Master FIFO empty |
| dqCount | output | NUM_DIES*DQ_CW | Occupancy of each die FIFO |
| dqFull | output | NUM_DIES | Die FIFO full flags |
| dqEmpty | output | NUM_DIES | Die FIFO empty flags |
| stallCount | output | STALL_W | Cycles the translated head was blocked |

## Verification
The assertions check four properties on every cycle:
- No queue is pushed while full or popped while empty.
- The master occupancy never drops unless a dispatch occurs.
- The stall counter moves only on a blocked cycle.
- A lookup pulse never lasts two cycles.

Other behaviours can only be shown by the bench's scenarios, because they compare values across many cycles against a model:
- Whether the table result is sampled in exactly the right cycle.
- Whether each die sees its entries in arrival order with the correct page and flag.
- Whether a single pop on a full die FIFO releases the blocked head in the next cycle.

// File: rtl/ftl_die_dispatch_pkg.sv
package ftl_die_dispatch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_HOLD  = 2'd2
  } dispState_t;

  typedef struct packed {
    logic lookupReq;
    logic capture;
    logic dispatch;
    logic stall;
  } ctrlStrobes_t;

endpackage

// File: rtl/ftl_fifo.sv
module ftl_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  assign popData = mem[rdPtr];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN) push |-> !full)
    else $error("push into full queue");

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty)
    else $error("pop from empty queue");

endmodule

// File: rtl/ftl_dispatch_ctrl.sv
module ftl_dispatch_ctrl
  import ftl_die_dispatch_pkg::*;
#(
  parameter int XLAT_LAT = 3,
  localparam int LCW = $clog2(XLAT_LAT + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         headValid,
  input  logic         targetFull,
  output ctrlStrobes_t strobes
);

  dispState_t     state;
  dispState_t     nextState;
  logic [LCW-1:0] latCnt;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (headValid) begin
          strobes.lookupReq = 1'b1;
          nextState         = ST_XLATE;
        end
      end
      ST_XLATE: begin
        if (latCnt == LCW'(XLAT_LAT)) begin
          strobes.capture = 1'b1;
          nextState       = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!targetFull) begin
          strobes.dispatch = 1'b1;
          nextState        = ST_IDLE;
        end else begin
          strobes.stall = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      latCnt <= '0;
    end else begin
      state <= nextState;
      if (strobes.lookupReq)      latCnt <= LCW'(1);
      else if (state == ST_XLATE) latCnt <= latCnt + LCW'(1);
    end
  end

  // R9
  single_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookupReq |=> !strobes.lookupReq)
    else $error("lookup issued twice in a row");

endmodule

// File: rtl/ftl_dispatch_dp.sv
module ftl_dispatch_dp
  import ftl_die_dispatch_pkg::*;
#(
  parameter int NUM_DIES = 4,
  parameter int MQ_DEPTH = 4,
  parameter int DQ_DEPTH = 8,
  parameter int LPA_W    = 8,
  parameter int PAGE_W   = 8,
  parameter int STALL_W  = 16,
  localparam int DIE_W = $clog2(NUM_DIES),
  localparam int MQ_CW = $clog2(MQ_DEPTH + 1),
  localparam int DQ_CW = $clog2(DQ_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  output logic                       headValid,
  output logic                       targetFull,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [LPA_W-1:0]           inLpa,
  input  logic                       inWrite,
  output logic [LPA_W-1:0]           lookupLpa,
  input  logic [DIE_W-1:0]           lookupDie,
  input  logic [PAGE_W-1:0]          lookupPage,
  output logic [NUM_DIES-1:0]        dieValid,
  input  logic [NUM_DIES-1:0]        dieReady,
  output logic [NUM_DIES*PAGE_W-1:0] diePage,
  output logic [NUM_DIES-1:0]        dieWrite,
  output logic [MQ_CW-1:0]           mqCount,
  output logic                       mqFull,
  output logic                       mqEmpty,
  output logic [NUM_DIES*DQ_CW-1:0]  dqCount,
  output logic [NUM_DIES-1:0]        dqFull,
  output logic [NUM_DIES-1:0]        dqEmpty,
  output logic [STALL_W-1:0]         stallCount
);

  logic [LPA_W:0]   mqHead;
  logic             mqPush;
  logic [DIE_W-1:0] curDie;
  logic [PAGE_W-1:0] curPage;
  logic             curWrite;
  logic [PAGE_W:0]  dqHead [NUM_DIES];

  assign inReady = !mqFull;
  assign mqPush  = inValid && !mqFull;

  ftl_fifo #(.WIDTH(LPA_W + 1), .DEPTH(MQ_DEPTH)) masterQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (mqPush),
    .pushData ({inWrite, inLpa}),
    .pop      (strobes.dispatch),
    .popData  (mqHead),
    .full     (mqFull),
    .empty    (mqEmpty),
    .count    (mqCount)
  );

  assign headValid = !mqEmpty;
  assign lookupLpa = mqHead[LPA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDie   <= '0;
      curPage  <= '0;
      curWrite <= 1'b0;
    end else if (strobes.capture) begin
      curDie   <= lookupDie;
      curPage  <= lookupPage;
      curWrite <= mqHead[LPA_W];
    end
  end

  assign targetFull = dqFull[curDie];

  for (genvar g = 0; g < NUM_DIES; g++) begin : gDie
    logic dqPush;
    logic dqPop;
    assign dqPush = strobes.dispatch && (curDie == DIE_W'(g));
    assign dqPop  = dieReady[g] && !dqEmpty[g];

    ftl_fifo #(.WIDTH(PAGE_W + 1), .DEPTH(DQ_DEPTH)) dieQ (
      .clk      (clk),
      .rstN     (rstN),
      .push     (dqPush),
      .pushData ({curWrite, curPage}),
      .pop      (dqPop),
      .popData  (dqHead[g]),
      .full     (dqFull[g]),
      .empty    (dqEmpty[g]),
      .count    (dqCount[g*DQ_CW +: DQ_CW])
    );

    assign dieValid[g]                 = !dqEmpty[g];
    assign diePage[g*PAGE_W +: PAGE_W] = dqHead[g][PAGE_W-1:0];
    assign dieWrite[g]                 = dqHead[g][PAGE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stallCount <= '0;
    else if (strobes.stall) stallCount <= stallCount + STALL_W'(1);
  end

  // R6
  hold_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dispatch |=> mqCount >= $past(mqCount))
    else $error("master queue shrank without a dispatch");

  // R7
  stall_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stall |=> $stable(stallCount))
    else $error("stall counter moved without a stall");

endmodule

// File: rtl/ftl_die_dispatch.sv
module ftl_die_dispatch
  import ftl_die_dispatch_pkg::*;
#(
  parameter int NUM_DIES = 4,
  parameter int MQ_DEPTH = 4,
  parameter int DQ_DEPTH = 8,
  parameter int LPA_W    = 8,
  parameter int PAGE_W   = 8,
  parameter int XLAT_LAT = 3,
  parameter int STALL_W  = 16,
  localparam int DIE_W = $clog2(NUM_DIES),
  localparam int MQ_CW = $clog2(MQ_DEPTH + 1),
  localparam int DQ_CW = $clog2(DQ_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [LPA_W-1:0]           inLpa,
  input  logic                       inWrite,
  output logic                       lookupReq,
  output logic [LPA_W-1:0]           lookupLpa,
  input  logic [DIE_W-1:0]           lookupDie,
  input  logic [PAGE_W-1:0]          lookupPage,
  output logic [NUM_DIES-1:0]        dieValid,
  input  logic [NUM_DIES-1:0]        dieReady,
  output logic [NUM_DIES*PAGE_W-1:0] diePage,
  output logic [NUM_DIES-1:0]        dieWrite,
  output logic [MQ_CW-1:0]           mqCount,
  output logic                       mqFull,
  output logic                       mqEmpty,
  output logic [NUM_DIES*DQ_CW-1:0]  dqCount,
  output logic [NUM_DIES-1:0]        dqFull,
  output logic [NUM_DIES-1:0]        dqEmpty,
  output logic [STALL_W-1:0]         stallCount
);

  ctrlStrobes_t strobes;
  logic         headValid;
  logic         targetFull;

  ftl_dispatch_ctrl #(.XLAT_LAT(XLAT_LAT)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .headValid  (headValid),
    .targetFull (targetFull),
    .strobes    (strobes)
  );

  ftl_dispatch_dp #(
    .NUM_DIES (NUM_DIES),
    .MQ_DEPTH (MQ_DEPTH),
    .DQ_DEPTH (DQ_DEPTH),
    .LPA_W    (LPA_W),
    .PAGE_W   (PAGE_W),
    .STALL_W  (STALL_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .headValid  (headValid),
    .targetFull (targetFull),
    .inValid    (inValid),
    .inReady    (inReady),
    .inLpa      (inLpa),
    .inWrite    (inWrite),
    .lookupLpa  (lookupLpa),
    .lookupDie  (lookupDie),
    .lookupPage (lookupPage),
    .dieValid   (dieValid),
    .dieReady   (dieReady),
    .diePage    (diePage),
    .dieWrite   (dieWrite),
    .mqCount    (mqCount),
    .mqFull     (mqFull),
    .mqEmpty    (mqEmpty),
    .dqCount    (dqCount),
    .dqFull     (dqFull),
    .dqEmpty    (dqEmpty),
    .stallCount (stallCount)
  );

  assign lookupReq = strobes.lookupReq;

endmodule

// File: tb/ftl_die_dispatch_test.sv
module ftl_die_dispatch_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_DIES = 4;
  localparam int MQ_DEPTH = 4;
  localparam int DQ_DEPTH = 8;
  localparam int LPA_W    = 8;
  localparam int PAGE_W   = 8;
  localparam int XLAT_LAT = 3;
  localparam int STALL_W  = 16;
  localparam int DIE_W    = $clog2(NUM_DIES);
  localparam int MQ_CW    = $clog2(MQ_DEPTH + 1);
  localparam int DQ_CW    = $clog2(DQ_DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                       rstN;
  logic                       inValid;
  logic                       inReady;
  logic [LPA_W-1:0]           inLpa;
  logic                       inWrite;
  logic                       lookupReq;
  logic [LPA_W-1:0]           lookupLpa;
  logic [DIE_W-1:0]           lookupDie;
  logic [PAGE_W-1:0]          lookupPage;
  logic [NUM_DIES-1:0]        dieValid;
  logic [NUM_DIES-1:0]        dieReady;
  logic [NUM_DIES*PAGE_W-1:0] diePage;
  logic [NUM_DIES-1:0]        dieWrite;
  logic [MQ_CW-1:0]           mqCount;
  logic                       mqFull;
  logic                       mqEmpty;
  logic [NUM_DIES*DQ_CW-1:0]  dqCount;
  logic [NUM_DIES-1:0]        dqFull;
  logic [NUM_DIES-1:0]        dqEmpty;
  logic [STALL_W-1:0]         stallCount;

  ftl_die_dispatch #(
    .NUM_DIES(NUM_DIES), .MQ_DEPTH(MQ_DEPTH), .DQ_DEPTH(DQ_DEPTH), .LPA_W(LPA_W),
    .PAGE_W(PAGE_W), .XLAT_LAT(XLAT_LAT), .STALL_W(STALL_W)
  ) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inLpa(inLpa),
    .inWrite(inWrite), .lookupReq(lookupReq), .lookupLpa(lookupLpa),
    .lookupDie(lookupDie), .lookupPage(lookupPage), .dieValid(dieValid),
    .dieReady(dieReady), .diePage(diePage), .dieWrite(dieWrite), .mqCount(mqCount),
    .mqFull(mqFull), .mqEmpty(mqEmpty), .dqCount(dqCount), .dqFull(dqFull),
    .dqEmpty(dqEmpty), .stallCount(stallCount)
  );

  int testsRun    = 0;
  int testsFailed = 0;
  int lookupPulses = 0;

  logic [PAGE_W:0]  expQ [NUM_DIES][$];
  logic [LPA_W-1:0] arrQ [$];

  // Mapping table model: result valid only XLAT_LAT cycles after the request.
  logic [XLAT_LAT-1:0] reqPipe = '0;
  always @(posedge clk) reqPipe <= {reqPipe[XLAT_LAT-2:0], lookupReq};

  always_comb begin
    if (reqPipe[XLAT_LAT-1]) begin
      lookupDie  = lookupLpa[DIE_W-1:0];
      lookupPage = lookupLpa ^ 8'hA5;
    end else begin
      lookupDie  = ~lookupLpa[DIE_W-1:0];
      lookupPage = 8'h00;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: lookup order (R5) and per-die delivery order and content (R8, R4).
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      if (lookupReq) begin
        lookupPulses++;
        if (arrQ.size() == 0) check("R5", "unexpected lookup", 32'(lookupLpa), 32'hFFFF);
        else check("R5", "lookup order", 32'(lookupLpa), 32'(arrQ.pop_front()));
      end
      for (int d = 0; d < NUM_DIES; d++) begin
        if (dieValid[d] && dieReady[d]) begin
          if (expQ[d].size() == 0)
            check("R8", "unexpected die entry", 32'({dieWrite[d], diePage[d*PAGE_W +: PAGE_W]}), 32'hFFFF);
          else
            check("R8", "die entry order", 32'({dieWrite[d], diePage[d*PAGE_W +: PAGE_W]}),
                  32'(expQ[d].pop_front()));
        end
      end
    end
  end

  // Called just after a negedge; returns just after a negedge.
  task automatic pushReq(input logic [LPA_W-1:0] lpa, input logic wr);
    inValid = 1'b1;
    inLpa   = lpa;
    inWrite = wr;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    arrQ.push_back(lpa);
    expQ[lpa[DIE_W-1:0]].push_back({wr, lpa ^ 8'hA5});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drainAll();
    dieReady = '1;
    repeat (200) @(negedge clk);
    dieReady = '0;
    #1;
    for (int d = 0; d < NUM_DIES; d++)
      check("R8", "die queue drained", 32'(expQ[d].size()), 32'd0);
    check("R5", "all requests looked up", 32'(arrQ.size()), 32'd0);
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "inReady in reset", 32'(inReady), 32'd1);
    check("R1", "mqEmpty in reset", 32'(mqEmpty), 32'd1);
    check("R1", "dqEmpty in reset", 32'(dqEmpty), 32'hF);
    check("R1", "dieValid in reset", 32'(dieValid), 32'd0);
    check("R1", "lookupReq in reset", 32'(lookupReq), 32'd0);
    check("R1", "stallCount in reset", 32'(stallCount), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "mqCount after reset", 32'(mqCount), 32'd0);
  endtask

  task automatic testLatency();
    int n;
    dieReady = '0;
    pushReq(8'h06, 1'b1);
    #1;
    check("R3", "lookupReq in first head cycle", 32'(lookupReq), 32'd1);
    check("R3", "lookupLpa is head page", 32'(lookupLpa), 32'h06);
    n = 0;
    while (!dieValid[2] && n < 20) begin
      @(negedge clk);
      #1;
      n++;
    end
    check("R4", "dispatch latency", 32'(n), 32'(XLAT_LAT + 2));
    check("R4", "page in die 2", 32'(diePage[2*PAGE_W +: PAGE_W]), 32'(8'h06 ^ 8'hA5));
    check("R4", "write flag in die 2", 32'(dieWrite[2]), 32'd1);
    check("R8", "die 2 count", 32'(dqCount[2*DQ_CW +: DQ_CW]), 32'd1);
    @(negedge clk);
    drainAll();
  endtask

  task automatic testStream();
    dieReady = '1;
    for (int i = 0; i < 12; i++) pushReq(LPA_W'(i * 7 + 1), i[0]);
    drainAll();
  endtask

  task automatic testHol();
    int s1;
    int p1;
    dieReady = '0;
    for (int i = 0; i < DQ_DEPTH; i++) pushReq(LPA_W'(i * 4), 1'b0);
    pushReq(8'h40, 1'b1);
    pushReq(8'h41, 1'b0);
    repeat (30) @(negedge clk);
    #1;
    check("R8", "die 0 full flag", 32'(dqFull[0]), 32'd1);
    check("R8", "die 0 count", 32'(dqCount[0 +: DQ_CW]), 32'(DQ_DEPTH));
    check("R6", "die 1 blocked behind head", 32'(dqEmpty[1]), 32'd1);
    check("R6", "master count held", 32'(mqCount), 32'd2);
    s1 = int'(stallCount);
    p1 = lookupPulses;
    repeat (10) @(negedge clk);
    #1;
    check("R7", "stall count per blocked cycle", 32'(stallCount), 32'(s1 + 10));
    check("R9", "no relookup while blocked", 32'(lookupPulses), 32'(p1));
    dieReady[0] = 1'b1;
    @(negedge clk);
    dieReady[0] = 1'b0;
    #1;
    check("R6", "slot freed", 32'(dqCount[0 +: DQ_CW]), 32'(DQ_DEPTH - 1));
    @(negedge clk);
    #1;
    check("R6", "head enters next cycle", 32'(dqCount[0 +: DQ_CW]), 32'(DQ_DEPTH));
    check("R6", "master count after release", 32'(mqCount), 32'd1);
    repeat (10) @(negedge clk);
    #1;
    check("R6", "die 1 served after release", 32'(dqEmpty[1]), 32'd0);
    @(negedge clk);
    drainAll();
  endtask

  task automatic testBackpressure();
    dieReady = '0;
    for (int i = 0; i < DQ_DEPTH + MQ_DEPTH; i++) pushReq(LPA_W'(i * 4 + 3), 1'b1);
    #1;
    check("R2", "mqCount at depth", 32'(mqCount), 32'(MQ_DEPTH));
    check("R2", "mqFull", 32'(mqFull), 32'd1);
    check("R2", "inReady low when full", 32'(inReady), 32'd0);
    inValid = 1'b1;
    inLpa   = 8'h77;
    inWrite = 1'b0;
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R2", "offer while full not stored", 32'(mqCount), 32'(MQ_DEPTH));
    @(negedge clk);
    drainAll();
  endtask

  initial begin
    #(8ns * 50000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    inValid  = 1'b0;
    inLpa    = '0;
    inWrite  = 1'b0;
    dieReady = '0;
    @(negedge clk);
    testReset();
    testLatency();
    testStream();
    testHol();
    testBackpressure();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule